// File: doc/BRIEF.md
# Panel Data Packer for STN and TFT Displays

This block sits between an internal pixel stream and the data pins of a flat panel. Each pixel arrives as three one-bit subpixels (red, green, blue). The block packs them into a 24-bit panel word in the form that the selected panel type expects. Three of the modes target passive-matrix (STN) panels. Two of those are dual-scan, where an upper-half stream and a lower-half stream are delivered concurrently and share each output word. The third is a single-scan mode with one 8-bit lane. A fourth mode passes a 24-bit TFT pixel through, one per clock.

Subpixels are packed continuously, lowest lane bit first, in the order R, G, B of one pixel and then R, G, B of the next. A pixel may therefore straddle two words. For an 8-bit lane, eight pixels fill exactly three words. A single-cycle shift enable marks each completed word. The same word and strobe also drive a signature port, which feeds an external CRC checker. Because each mode lays out the pixels differently, the signature of a fixed image depends on the mode.

The mode is sampled only on the first pixel of a frame. The packing phase restarts on the first pixel of every line.

Top module: `panel_pack`

## Requirements
- R1: While reset is held and in the first cycle after it, `panel_data` and `sig_data` are 0 and `shift_en` and `sig_valid` are 0. The reset mode is a reserved (quiet) one.
- R2: `mode_sel` is sampled only in a cycle with `pix_valid` and `frame_start` both high, and takes effect for that pixel. In all other cycles a change of `mode_sel` has no effect on the packing.
- R3: Code 3'b011 selects single-scan 8-bit mode. Each pixel is `{B,G,R}` = `up_pix[2:0]`. Pixels pack R,G,B upward from bit 0. Eight pixels give three words whose bits 7:0 are the upper stream bits 7:0, then 15:8, then 23:16. Bits 23:8 are 0 and `lo_pix` is ignored.
- R4: Code 3'b001 selects dual-scan 16-bit mode. Bits 7:0 carry the upper lane and bits 15:8 carry the lower lane, both packed as in R3 and in the same word. Bits 23:16 are 0.
- R5: Code 3'b010 selects dual-scan 24-bit mode. Every 4 pixels form one word, with the 12 upper-stream bits in bits 11:0 and the 12 lower-stream bits in bits 23:12.
- R6: Code 3'b000 selects TFT mode. Each valid pixel's `tft_pix` appears on `panel_data` one cycle later, with `shift_en` high.
- R7: Codes 3'b100 to 3'b111 are reserved. `panel_data` is 0 and `shift_en` stays low.
- R8: A valid pixel with `line_start` or `frame_start` high restarts the packing at phase 1 and bit 0. The bits of an incomplete word from the previous line are discarded.
- R9: `sig_data` equals `panel_data` and `sig_valid` equals `shift_en` in every cycle.
- R10: `shift_en` is high for exactly the one cycle after the pixel that completes a word. In STN modes it is low in all other cycles, and `panel_data` holds its last word between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Panel type code, sampled at frame start |
| pix_valid | input | 1 | A pixel is present on the pixel inputs |
| frame_start | input | 1 | Qualifies the first pixel of a frame |
| line_start | input | 1 | Qualifies the first pixel of a line |
| up_pix | input | 3 | Upper-half (or single-scan) pixel, {B,G,R} |
| lo_pix | input | 3 | Lower-half pixel for dual-scan modes, {B,G,R} |
| tft_pix | input | 24 | Pixel for TFT pass-through |
| panel_data | output | 24 | Packed panel word, registered |
| shift_en | output | 1 | One-cycle pulse per completed word |
| sig_data | output | 24 | Word presented to the signature generator |
| sig_valid | output | 1 | Strobe for `sig_data` |

## Verification
A fill counter that is wrong, or a remainder that is dropped, shifts every later bit in the line. The first word after the fault then shows misplaced subpixels, and `shift_en` fires a pixel early or late, within three pixels. A wrong latched mode shows in the first word of the line, as nonzero unused bits or a wrong word cadence. A mode that is latched outside a frame start shows on the next word of a line that should have kept the old format. A phase that is not reset at a line start shows on the first word of the new line.

// File: rtl/panel_pack_pkg.sv
package panel_pack_pkg;
  localparam int unsigned SUBPIX = 3;
  localparam logic [2:0] MODE_TFT     = 3'b000;
  localparam logic [2:0] MODE_DUAL16  = 3'b001;
  localparam logic [2:0] MODE_DUAL24  = 3'b010;
  localparam logic [2:0] MODE_SINGLE8 = 3'b011;
  localparam logic [2:0] MODE_QUIET   = 3'b111;

  function automatic logic is_stn(input logic [2:0] m);
    return (m == MODE_DUAL16) || (m == MODE_DUAL24) || (m == MODE_SINGLE8);
  endfunction
endpackage

// File: rtl/pack_phase.sv
module pack_phase #(
  parameter int unsigned PIX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic             restart,
  input  logic [CNT_W-1:0] lane_w,
  output logic [CNT_W-1:0] fill_eff,
  output logic             emit
);
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W:0]   sum;

  assign fill_eff = restart ? '0 : fill_q;
  assign sum      = {1'b0, fill_eff} + (CNT_W+1)'(PIX_W);
  assign emit     = pix_valid && (sum >= {1'b0, lane_w});

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (pix_valid) begin
      if (emit) fill_q <= CNT_W'(sum - {1'b0, lane_w});
      else      fill_q <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pack_lane.sv
module pack_lane #(
  parameter int unsigned PIX_W  = 3,
  parameter int unsigned LANE_W = 12,
  parameter int unsigned ACC_W  = 14,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic              restart,
  input  logic              emit,
  input  logic [PIX_W-1:0]  pix,
  input  logic [CNT_W-1:0]  fill_eff,
  input  logic [CNT_W-1:0]  lane_w,
  output logic [LANE_W-1:0] word
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] merged;

  assign merged = (restart ? '0 : acc_q) | (ACC_W'(pix) << fill_eff);
  assign word   = merged[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (pix_valid) begin
      acc_q <= emit ? (merged >> lane_w) : merged;
    end
  end
endmodule

// File: rtl/panel_pack.sv
module panel_pack #(
  parameter int unsigned OUT_W = 24
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [2:0]                            mode_sel,
  input  logic                                  pix_valid,
  input  logic                                  frame_start,
  input  logic                                  line_start,
  input  logic [panel_pack_pkg::SUBPIX-1:0]     up_pix,
  input  logic [panel_pack_pkg::SUBPIX-1:0]     lo_pix,
  input  logic [OUT_W-1:0]                      tft_pix,
  output logic [OUT_W-1:0]                      panel_data,
  output logic                                  shift_en,
  output logic [OUT_W-1:0]                      sig_data,
  output logic                                  sig_valid
);
  import panel_pack_pkg::*;

  localparam int unsigned PIX_W  = SUBPIX;
  localparam int unsigned NARROW = OUT_W / 3;
  localparam int unsigned WIDE   = OUT_W / 2;
  localparam int unsigned ACC_W  = WIDE + PIX_W - 1;
  localparam int unsigned CNT_W  = $clog2(ACC_W + 1);

  logic [2:0]        act_mode_q;
  logic [2:0]        eff_mode;
  logic              restart, stn_valid, emit;
  logic [CNT_W-1:0]  lane_w, fill_eff;
  logic [PIX_W-1:0]  lane_pix  [2];
  logic [WIDE-1:0]   lane_word [2];
  logic [OUT_W-1:0]  word_c;
  logic [OUT_W-1:0]  data_q;
  logic              strobe_q;

  assign eff_mode  = (pix_valid && frame_start) ? mode_sel : act_mode_q;
  assign restart   = frame_start || line_start;
  assign stn_valid = pix_valid && is_stn(eff_mode);
  assign lane_w    = (eff_mode == MODE_DUAL24) ? CNT_W'(WIDE) : CNT_W'(NARROW);
  assign lane_pix[0] = up_pix;
  assign lane_pix[1] = lo_pix;

  pack_phase #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .pix_valid(stn_valid), .restart(restart),
    .lane_w(lane_w), .fill_eff(fill_eff), .emit(emit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    pack_lane #(.PIX_W(PIX_W), .LANE_W(WIDE), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst(rst), .pix_valid(stn_valid), .restart(restart),
      .emit(emit), .pix(lane_pix[g]), .fill_eff(fill_eff), .lane_w(lane_w),
      .word(lane_word[g])
    );
  end

  always_comb begin
    case (eff_mode)
      MODE_DUAL16:  word_c = {{(OUT_W-2*NARROW){1'b0}},
                              lane_word[1][NARROW-1:0], lane_word[0][NARROW-1:0]};
      MODE_DUAL24:  word_c = {lane_word[1], lane_word[0]};
      MODE_SINGLE8: word_c = {{(OUT_W-NARROW){1'b0}}, lane_word[0][NARROW-1:0]};
      default:      word_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode_q <= MODE_QUIET;
      data_q     <= '0;
      strobe_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (pix_valid && frame_start) act_mode_q <= mode_sel;
      if (eff_mode == MODE_TFT) begin
        if (pix_valid) begin
          data_q   <= tft_pix;
          strobe_q <= 1'b1;
        end
      end else if (!is_stn(eff_mode)) begin
        data_q <= '0;
      end else if (emit) begin
        data_q   <= word_c;
        strobe_q <= 1'b1;
      end
    end
  end

  assign panel_data = data_q;
  assign shift_en   = strobe_q;
  assign sig_data   = data_q;
  assign sig_valid  = strobe_q;
endmodule

// File: rtl/panel_pack_chk.sv
module panel_pack_chk #(
  parameter int unsigned OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             frame_start,
  input logic [2:0]       act_mode,
  input logic [OUT_W-1:0] panel_data,
  input logic             shift_en
);
  p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    act_mode[2] |-> (panel_data == '0 && !shift_en));

  p_single8_high_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && act_mode == 3'b011) |-> (panel_data[OUT_W-1:OUT_W/3] == '0));

  p_dual16_top_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && act_mode == 3'b001) |-> (panel_data[OUT_W-1:2*OUT_W/3] == '0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(pix_valid && frame_start) |=> $stable(act_mode));

  p_strobe_after_pixel_r10: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> $past(pix_valid));
endmodule

bind panel_pack panel_pack_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .frame_start(frame_start),
  .act_mode(act_mode_q), .panel_data(panel_data), .shift_en(shift_en)
);

// File: tb/panel_pack_bench.sv
`timescale 1ns/1ps
module panel_pack_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_sel = 3'b000;
  logic        pix_valid = 1'b0, frame_start = 1'b0, line_start = 1'b0;
  logic [2:0]  up_pix = '0, lo_pix = '0;
  logic [23:0] tft_pix = '0;
  logic [23:0] panel_data, sig_data;
  logic        shift_en, sig_valid;

  int tests = 0, fails = 0, ncap = 0, sig_bad = 0;
  logic [23:0] cap [16];
  bit done = 0;

  always #2 clk = ~clk;

  panel_pack u_panel_pack (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pix_valid(pix_valid),
    .frame_start(frame_start), .line_start(line_start), .up_pix(up_pix),
    .lo_pix(lo_pix), .tft_pix(tft_pix), .panel_data(panel_data),
    .shift_en(shift_en), .sig_data(sig_data), .sig_valid(sig_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (shift_en && ncap < 16) begin cap[ncap] = panel_data; ncap++; end
      if (sig_data !== panel_data || sig_valid !== shift_en) sig_bad++;
    end
  end

  localparam logic [50:0] VEC [5] = '{
    {3'b011, 24'hC3A55A, 24'hFFFFFF},
    {3'b001, 24'h9E3710, 24'h6B2DF4},
    {3'b010, 24'h1F2E3D, 24'hA0B1C2},
    {3'b000, 24'h123456, 24'h000000},
    {3'b110, 24'hFFFFFF, 24'hFFFFFF}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] tft_val(input logic [23:0] pu, input int i);
    logic [7:0] b = 8'(i);
    return pu ^ {b, b, b};
  endfunction

  function automatic int words_per_line(input logic [2:0] m, input int npix);
    case (m)
      3'b000:         return npix;
      3'b001, 3'b011: return (npix * 3) / 8;
      3'b010:         return npix / 4;
      default:        return 0;
    endcase
  endfunction

  function automatic bit exp_strobe(input logic [2:0] m, input int i);
    case (m)
      3'b000:         return 1'b1;
      3'b001, 3'b011: return (i == 2 || i == 5 || i == 7);
      3'b010:         return (i == 3 || i == 7);
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] exp_word(input logic [2:0] m, input logic [23:0] pu,
                                           input logic [23:0] pl, input int k);
    case (m)
      3'b000:  return tft_val(pu, k);
      3'b001:  return {8'h00, pl[8*k +: 8], pu[8*k +: 8]};
      3'b010:  return {pl[12*k +: 12], pu[12*k +: 12]};
      3'b011:  return {16'h0000, pu[8*k +: 8]};
      default: return 24'h0;
    endcase
  endfunction

  // drives one line; checks strobe cadence against the active mode m_exp (R10)
  task automatic run_line(input logic [2:0] m_drv, input logic [2:0] m_exp, input bit is_frame,
                          input logic [23:0] pu, input logic [23:0] pl, input int npix);
    int bad = 0;
    ncap = 0;
    for (int i = 0; i < npix; i++) begin
      @(negedge clk);
      if (i > 0 && shift_en !== exp_strobe(m_exp, i-1)) bad++;
      mode_sel    = m_drv;
      pix_valid   = 1'b1;
      frame_start = is_frame && (i == 0);
      line_start  = (i == 0);
      up_pix      = pu[3*i +: 3];
      lo_pix      = pl[3*i +: 3];
      tft_pix     = tft_val(pu, i);
    end
    @(negedge clk);
    if (shift_en !== exp_strobe(m_exp, npix-1)) bad++;
    pix_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
    @(negedge clk);
    if (m_exp != 3'b000 && shift_en !== 1'b0) bad++;
    @(negedge clk);
    check(bad == 0, "R10 strobe cadence", 32'(bad), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(panel_data == 0 && shift_en == 0, "R1 reset in reset", {7'b0, shift_en, panel_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(panel_data == 0 && shift_en == 0 && sig_valid == 0 && sig_data == 0,
          "R1 after reset", {7'b0, shift_en, panel_data}, 0);

    // vector table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 5; v++) begin
      logic [2:0]  m  = VEC[v][50:48];
      logic [23:0] pu = VEC[v][47:24];
      logic [23:0] pl = VEC[v][23:0];
      string tag;
      case (m)
        3'b011:  tag = "R3 single8";
        3'b001:  tag = "R4 dual16";
        3'b010:  tag = "R5 dual24";
        3'b000:  tag = "R6 tft";
        default: tag = "R7 reserved";
      endcase
      run_line(m, m, 1'b1, pu, pl, 8);
      check(ncap == words_per_line(m, 8), {tag, " word count"}, 32'(ncap), 32'(words_per_line(m, 8)));
      for (int k = 0; k < ncap && k < words_per_line(m, 8); k++)
        check(cap[k] == exp_word(m, pu, pl, k), {tag, " word"}, {8'h0, cap[k]}, {8'h0, exp_word(m, pu, pl, k)});
      if (m[2]) check(panel_data == 0, "R7 output zero", {8'h0, panel_data}, 0);
    end

    // R8: partial line then restart at phase 1
    run_line(3'b011, 3'b011, 1'b1, 24'hFFFFFF, 24'h0, 2);
    check(ncap == 0, "R8 partial line no word", 32'(ncap), 0);
    run_line(3'b011, 3'b011, 1'b0, 24'h5A3C96, 24'h0, 8);
    check(ncap == 3 && cap[0] == 24'h000096, "R8 restart first word", {8'h0, cap[0]}, 32'h96);
    check(cap[2] == 24'h00005A, "R8 restart last word", {8'h0, cap[2]}, 32'h5A);

    // R2: mode change without frame start is ignored
    run_line(3'b010, 3'b010, 1'b1, 24'h000ABC, 24'h000123, 4);
    check(ncap == 1 && cap[0] == 24'h123ABC, "R2 dual24 frame", {8'h0, cap[0]}, 32'h123ABC);
    run_line(3'b011, 3'b010, 1'b0, 24'h000F0E, 24'h000D0C, 4);
    check(ncap == 1 && cap[0] == 24'hD0CF0E, "R2 mode held mid frame", {8'h0, cap[0]}, 32'hD0CF0E);

    // R10: output holds last word after strobe
    check(panel_data == 24'hD0CF0E && shift_en == 0, "R10 hold between words",
          {7'b0, shift_en, panel_data}, 32'hD0CF0E);

    // R2: a new mode takes effect at the next frame start
    run_line(3'b011, 3'b011, 1'b1, 24'h00FF81, 24'hFFFFFF, 8);
    check(ncap == 3 && cap[0] == 24'h000081, "R2 switch at frame", {8'h0, cap[0]}, 32'h81);

    check(sig_bad == 0, "R9 signature mirrors output", 32'(sig_bad), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule